// File: doc/BRIEF.md
# Belief Accumulation and Disparity Selector

This block is the final stage of a block-wise belief-propagation stereo matcher. Once the message-passing iterations on a block are finished, it takes one node per handshake: the node's matching-cost vector and the four incoming message vectors (from the north, south, west and east neighbours), each holding one unsigned value per disparity level. For every disparity it adds the five terms into a belief, and it picks the disparity whose belief is smallest. That index is the node's disparity result.

Results are collected in a row buffer. When a full row is present, the buffer raises a burst-write request toward the external-memory side and holds it until that side accepts it. The unit is kept idle by a start input, because it shares single-port internal memories with the message updater. A block is `ROW_NODES` × `BLOCK_ROWS` nodes. After its last row has been written, a one-cycle done pulse returns the unit to idle.

The control is a four-state machine:
- ST_IDLE waits for start.
- ST_GATHER accepts nodes and moves to ST_FLUSH when the last slot of a row is filled.
- ST_FLUSH holds the write request. On acceptance it goes back to ST_GATHER, or to ST_DONE after the final row of the block.
- ST_DONE lasts one cycle and then returns to ST_IDLE.

Top module: `belief_disparity_selector`

## Requirements
- R1: The belief at disparity d is the exact sum of the cost and the N, S, W and E message values at d. The sum is kept in `COST_W+3` bits, so five maximal terms (5×255 = 1275 for 8-bit terms) never wrap. Each vector port carries disparity d in bits [d*COST_W +: COST_W].
- R2: The result for a node is the disparity index whose belief is smallest.
- R3: When several disparities share the smallest belief, the lowest index is chosen.
- R4: A node is consumed only in a cycle where `node_valid` and `node_ready` are both high. Each consumed node yields exactly one result.
- R5: The k-th node consumed in a row (k counted from 0) is placed in `wr_data` bits [k*DISP_W +: DISP_W]. `wr_valid` rises in the cycle after the edge that consumed the row's `ROW_NODES`-th node.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid` and `wr_data` hold their values and `node_ready` stays low. A row is written at the edge where both are high.
- R7: After the write of row `BLOCK_ROWS`, `done` is high for exactly one cycle. The unit then stays idle with `node_ready` low until the next start.
- R8: `start` has no effect outside ST_IDLE. `node_valid` has no effect in ST_IDLE, where `node_ready` is low.
- R9: During and just after reset, `node_ready`, `wr_valid` and `done` are low and the unit is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block; only seen in ST_IDLE |
| node_valid | input | 1 | A node's vectors are present |
| node_ready | output | 1 | Unit accepts a node this cycle |
| cost_vec | input | DISP_LEVELS*COST_W | Matching cost per disparity |
| msg_n | input | DISP_LEVELS*COST_W | Message from the north neighbour |
| msg_s | input | DISP_LEVELS*COST_W | Message from the south neighbour |
| msg_w | input | DISP_LEVELS*COST_W | Message from the west neighbour |
| msg_e | input | DISP_LEVELS*COST_W | Message from the east neighbour |
| wr_valid | output | 1 | Full row of results awaiting write |
| wr_ready | input | 1 | Memory side accepts the row |
| wr_data | output | ROW_NODES*DISP_W | Packed row of disparity results |
| done | output | 1 | One-cycle pulse after the block's last row |

## Verification
The belief sum and the argmin are combinational, so a node's result is written into its row slot at the same edge that consumes the node. The bench therefore releases `node_valid` at the following falling edge. The row request is due one cycle after the edge that consumed the row's last node, so the bench reads `wr_valid` and the whole packed `wr_data` at the falling edge right after the send task returns. The state after a write is settled at the edge where `wr_ready` is seen high: `wr_valid` has fallen, or `done` has risen, by the next falling edge. The `done` flag is checked there and again one falling edge later, by which time it must have cleared.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_DONE   = 2'd3
    } sel_state_t;

endpackage

// File: rtl/belief_sum.sv
module belief_sum #(
    parameter int DISP_LEVELS = 32,
    parameter int COST_W      = 8,
    parameter int SUM_W       = COST_W + 3
) (
    input  logic [DISP_LEVELS*COST_W-1:0] cost_vec,
    input  logic [DISP_LEVELS*COST_W-1:0] msg_n,
    input  logic [DISP_LEVELS*COST_W-1:0] msg_s,
    input  logic [DISP_LEVELS*COST_W-1:0] msg_w,
    input  logic [DISP_LEVELS*COST_W-1:0] msg_e,
    output logic [DISP_LEVELS*SUM_W-1:0]  belief_flat
);

    // One five-input adder per disparity level (R1)
    for (genvar d = 0; d < DISP_LEVELS; d++) begin : g_lvl
        assign belief_flat[d*SUM_W +: SUM_W] =
              SUM_W'(cost_vec[d*COST_W +: COST_W])
            + SUM_W'(msg_n[d*COST_W +: COST_W])
            + SUM_W'(msg_s[d*COST_W +: COST_W])
            + SUM_W'(msg_w[d*COST_W +: COST_W])
            + SUM_W'(msg_e[d*COST_W +: COST_W]);
    end

endmodule

// File: rtl/argmin_tree.sv
module argmin_tree #(
    parameter int DISP_LEVELS = 32,
    parameter int SUM_W       = 11,
    parameter int IDX_W       = $clog2(DISP_LEVELS)
) (
    input  logic [DISP_LEVELS*SUM_W-1:0] belief_flat,
    output logic [IDX_W-1:0]             min_idx,
    output logic [SUM_W-1:0]             min_val
);

    localparam int LEAVES = 1 << IDX_W;

    // Binary reduction; the left operand always carries the lower indices,
    // so the right one wins only when strictly smaller (R3)
    for (genvar lv = 0; lv <= IDX_W; lv++) begin : g_lv
        localparam int CNT = LEAVES >> lv;
        logic [SUM_W-1:0] val [CNT];
        logic [IDX_W-1:0] idx [CNT];
        for (genvar k = 0; k < CNT; k++) begin : g_nd
            if (lv == 0) begin : g_leaf
                if (k < DISP_LEVELS) begin : g_real
                    assign val[k] = belief_flat[k*SUM_W +: SUM_W];
                end else begin : g_pad
                    assign val[k] = '1;
                end
                assign idx[k] = IDX_W'(k);
            end else begin : g_cmp
                logic right_wins;
                assign right_wins = g_lv[lv-1].val[2*k+1] < g_lv[lv-1].val[2*k];
                assign val[k] = right_wins ? g_lv[lv-1].val[2*k+1] : g_lv[lv-1].val[2*k];
                assign idx[k] = right_wins ? g_lv[lv-1].idx[2*k+1] : g_lv[lv-1].idx[2*k];
            end
        end
    end

    assign min_idx = g_lv[IDX_W].idx[0];
    assign min_val = g_lv[IDX_W].val[0];

endmodule

// File: rtl/result_packer.sv
module result_packer #(
    parameter int ROW_NODES = 32,
    parameter int IDX_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       clear,
    input  logic [IDX_W-1:0]           din,
    output logic [ROW_NODES*IDX_W-1:0] row_flat,
    output logic                       last_slot
);

    localparam int SLOT_W = $clog2(ROW_NODES);

    logic [SLOT_W-1:0]          slot_q;
    logic [ROW_NODES*IDX_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            row_q  <= '0;
        end else if (clear) begin
            slot_q <= '0;
        end else if (push) begin
            row_q[slot_q*IDX_W +: IDX_W] <= din;
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end
    end

    assign last_slot = (slot_q == SLOT_W'(ROW_NODES - 1));
    assign row_flat  = row_q;

endmodule

// File: rtl/belief_disparity_selector.sv
module belief_disparity_selector
    import bsel_pkg::*;
#(
    parameter int DISP_LEVELS = 32,
    parameter int COST_W      = 8,
    parameter int ROW_NODES   = 32,
    parameter int BLOCK_ROWS  = 32,
    localparam int DISP_W     = $clog2(DISP_LEVELS),
    localparam int SUM_W      = COST_W + 3,
    localparam int VEC_W      = DISP_LEVELS * COST_W,
    localparam int ROW_W      = ROW_NODES * DISP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             node_valid,
    output logic             node_ready,
    input  logic [VEC_W-1:0] cost_vec,
    input  logic [VEC_W-1:0] msg_n,
    input  logic [VEC_W-1:0] msg_s,
    input  logic [VEC_W-1:0] msg_w,
    input  logic [VEC_W-1:0] msg_e,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [ROW_W-1:0] wr_data,
    output logic             done
);

    localparam int RC_W = $clog2(BLOCK_ROWS + 1);

    sel_state_t state_q, state_d;
    logic [RC_W-1:0] row_q;
    logic [DISP_LEVELS*SUM_W-1:0] belief_flat;
    logic [DISP_W-1:0] min_idx;
    logic [SUM_W-1:0]  min_val;
    logic accept, row_out, last_slot, final_row;

    belief_sum #(.DISP_LEVELS(DISP_LEVELS), .COST_W(COST_W), .SUM_W(SUM_W)) u_sum (
        .cost_vec(cost_vec), .msg_n(msg_n), .msg_s(msg_s),
        .msg_w(msg_w), .msg_e(msg_e), .belief_flat(belief_flat)
    );

    argmin_tree #(.DISP_LEVELS(DISP_LEVELS), .SUM_W(SUM_W), .IDX_W(DISP_W)) u_min (
        .belief_flat(belief_flat), .min_idx(min_idx), .min_val(min_val)
    );

    result_packer #(.ROW_NODES(ROW_NODES), .IDX_W(DISP_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .push(accept), .clear(row_out),
        .din(min_idx), .row_flat(wr_data), .last_slot(last_slot)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Row counter within the block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            row_q <= '0;
        else if (state_q == ST_IDLE && start)  row_q <= '0;
        else if (row_out)                      row_q <= row_q + 1'b1;
    end

    assign final_row = (row_q == RC_W'(BLOCK_ROWS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_GATHER;
            ST_GATHER: if (accept && last_slot) state_d = ST_FLUSH;
            ST_FLUSH:  if (wr_ready) state_d = final_row ? ST_DONE : ST_GATHER;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        node_ready = 1'b0;
        wr_valid   = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_GATHER: node_ready = 1'b1;
            ST_FLUSH:  wr_valid   = 1'b1;
            ST_DONE:   done       = 1'b1;
        endcase
    end

    assign accept  = node_valid && node_ready;
    assign row_out = wr_valid && wr_ready;

    // ---------------- assertions ----------------
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

    assert_no_take_in_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !node_ready);

    assert_row_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && last_slot |=> wr_valid);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !node_ready && !wr_valid);

    always_ff @(posedge clk) begin
        if (rst_n && accept) begin
            for (int d = 0; d < DISP_LEVELS; d++) begin
                assert_min_R2: assert (belief_flat[d*SUM_W +: SUM_W] >= min_val);
                if (d < int'(min_idx)) begin
                    assert_tie_low_R3: assert (belief_flat[d*SUM_W +: SUM_W] > min_val);
                end
            end
        end
    end

endmodule

// File: tb/sim_belief_disparity_selector.sv
module sim_belief_disparity_selector;

    localparam int L  = 32;
    localparam int CW = 8;
    localparam int RN = 4;
    localparam int BR = 2;
    localparam int IW = 5;

    // Stimulus table: seed of each pattern node for block 1
    localparam logic [7:0] SEEDS [8] = '{8'd3, 8'd17, 8'd42, 8'd99, 8'd128, 8'd201, 8'd7, 8'd250};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, node_valid = 1'b0, wr_ready = 1'b0;
    logic [L*CW-1:0] cost_vec = '0, msg_n = '0, msg_s = '0, msg_w = '0, msg_e = '0;
    logic node_ready, wr_valid, done;
    logic [RN*IW-1:0] wr_data;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [7:0] tc [5][L];
    logic [RN*IW-1:0] exp_row;

    always #4 clk = ~clk;

    belief_disparity_selector #(.DISP_LEVELS(L), .COST_W(CW), .ROW_NODES(RN), .BLOCK_ROWS(BR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .node_valid(node_valid), .node_ready(node_ready),
        .cost_vec(cost_vec), .msg_n(msg_n), .msg_s(msg_s), .msg_w(msg_w), .msg_e(msg_e),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_all(input int v);
        for (int t = 0; t < 5; t++) for (int d = 0; d < L; d++) tc[t][d] = 8'(v);
    endtask

    task automatic fill_seed(input int s);
        for (int t = 0; t < 5; t++)
            for (int d = 0; d < L; d++)
                tc[t][d] = 8'((s * (t + 1) * 7 + (d * d + s) * (t + 3) + d * s) % 256);
    endtask

    function automatic int ref_pick();
        int best = 0, bv = 1 << 30;
        for (int d = 0; d < L; d++) begin
            int s = 0;
            for (int t = 0; t < 5; t++) s += int'(tc[t][d]);
            if (s < bv) begin bv = s; best = d; end
        end
        return best;
    endfunction

    // Drive one node and wait until it is consumed (R4)
    task automatic send_node();
        @(negedge clk);
        for (int d = 0; d < L; d++) begin
            cost_vec[d*CW +: CW] = tc[0][d];
            msg_n[d*CW +: CW]    = tc[1][d];
            msg_s[d*CW +: CW]    = tc[2][d];
            msg_w[d*CW +: CW]    = tc[3][d];
            msg_e[d*CW +: CW]    = tc[4][d];
        end
        node_valid = 1'b1;
        while (!node_ready) @(negedge clk);
        @(negedge clk);
        node_valid = 1'b0;
    endtask

    task automatic put(input int slot, input string req);
        int r;
        r = ref_pick();
        exp_row[slot*IW +: IW] = IW'(r);
        send_node();
        if (slot < RN - 1) chk(!wr_valid, {req, " no early request"}, int'(wr_valid), 0);
    endtask

    // At the negedge after the row's last node: check request, hold, write
    task automatic finish_row(input int hold, input string req);
        chk(wr_valid === 1'b1, "R5 request after last node", int'(wr_valid), 1);
        chk(wr_data === exp_row, {req, " R5 packed row"}, int'(wr_data), int'(exp_row));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(wr_valid === 1'b1 && wr_data === exp_row, "R6 held while not ready",
                int'(wr_data), int'(exp_row));
            chk(!node_ready, "R6 no node taken in flush", int'(node_ready), 0);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        chk(!wr_valid, "R6 request drops after write", int'(wr_valid), 0);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!node_ready && !wr_valid && !done, "R9 outputs in reset", int'({node_ready, wr_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!node_ready && !wr_valid && !done, "R9 outputs after reset", int'({node_ready, wr_valid, done}), 0);

        // R8: node offered while idle is not taken
        fill_seed(5);
        node_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!node_ready && !wr_valid, "R8 idle ignores node_valid", int'(node_ready), 0);
        end
        node_valid = 1'b0;

        // Block 1: table walk
        pulse_start();
        for (int i = 0; i < RN * BR; i++) begin
            fill_seed(int'(SEEDS[i]));
            put(i % RN, "R2 table");
            if (i == 1) begin
                pulse_start();   // R8: start mid-block must not disturb packing
                chk(node_ready, "R8 start ignored in gather", int'(node_ready), 1);
            end
            if (i % RN == RN - 1) begin
                finish_row(i == RN - 1 ? 0 : 2, "R2");
                if (i < RN * BR - 1) chk(node_ready, "R6 back to gather", int'(node_ready), 1);
            end
        end
        chk(done === 1'b1, "R7 done after last row", int'(done), 1);
        @(negedge clk);
        chk(!done && !node_ready, "R7 done is one cycle, idle", int'({done, node_ready}), 0);

        // Block 2: directed corner cases
        pulse_start();
        // R3 tie between 5 and 20
        fill_all(100); tc[0][5] = 8'd10; tc[0][20] = 8'd10;
        put(0, "R3 tie");
        // R1 all terms maximal: every belief 1275, lowest index
        fill_all(255);
        put(1, "R1 max terms");
        // R2 minimum at last index
        fill_all(50); tc[0][31] = 8'd0;
        put(2, "R2 last index");
        // R1 no wrap: d9 sums to 1275, others 1000
        fill_all(200); for (int t = 0; t < 5; t++) tc[t][9] = 8'd255;
        put(3, "R1 no wrap");
        chk(exp_row[3*IW +: IW] == 0, "R1 reference", int'(exp_row[3*IW +: IW]), 0);
        finish_row(3, "R1 R3");
        // R1 east message counted
        fill_all(80); tc[0][3] = 8'd10; tc[4][12] = 8'd0;
        put(0, "R1 east term");
        chk(exp_row[IW-1:0] == 5'd12, "R1 reference east", int'(exp_row[IW-1:0]), 12);
        // R1 north message counted
        fill_all(80); tc[0][1] = 8'd15; tc[1][8] = 8'd0;
        put(1, "R1 north term");
        fill_seed(61);
        put(2, "R2 pattern");
        fill_seed(177);
        put(3, "R2 pattern");
        finish_row(1, "R1 R2");
        chk(done === 1'b1, "R7 done block 2", int'(done), 1);
        @(negedge clk);
        chk(!done && !node_ready && !wr_valid, "R7 idle after block 2", int'({done, node_ready}), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule